// File: doc/BRIEF.md
# Secure-Aware Exception Priority Selector

This block looks at every pending exception request of a processor core, namely a handful of system exceptions numbered 1 to 15 and N peripheral interrupts numbered from 16 upward. It decides which single request should be taken next. Some system exceptions have fixed, negative priority levels. The others carry a software-programmed level from 0 to 2^P-1. A request is taken only when its level is strictly more urgent than the current execution priority of the core.

For each candidate the block also works out the security state it targets. One global routing bit moves NMI, BusFault and HardFault between the Secure and Non-secure worlds. When that bit is set, a Secure-targeted HardFault is lifted to level -3, which lets it overtake NMI. Per-interrupt assignment bits place each peripheral interrupt in one world. Banked system exceptions take their target from the bank that raised them.

The block holds the enable bits and the interrupt assignment bits behind a one-beat configuration write port. That port enforces the rule that Non-secure software cannot change anything that belongs to the Secure world. The winner's exception number, its vector address and its target state are registered and come with a valid flag.

Top module: `exc_prio_sel`

## Requirements
- R1: A reset request (system line 1) has level -4 and targets Secure. It is selected whenever it is pending and the execution priority is above -4.
- R2: NMI (line 2) has level -2 and cannot be disabled. It targets Secure when `routeNs` is 0 and Non-secure when `routeNs` is 1.
- R3: HardFault (line 3) cannot be disabled. When `routeNs` is 0 it targets Secure at level -1. When `routeNs` is 1 it targets Non-secure at level -1 if `hfTargetNs` is 1, and Secure at level -3 if `hfTargetNs` is 0. At level -3 it beats NMI.
- R4: Exceptions 4, 5, 6, 7, 11, 12, 14 and 15 use the level in `sysPrio[n*P +: P]`. BusFault (5) targets the state given by `routeNs`. SecureFault (7) always targets Secure. 4, 6, 11, 12, 14 and 15 target Non-secure exactly when `sysBankNs[n]` is 1.
- R5: Numbers 0, 8, 9, 10 and 13 are never selected, even when their `sysPend` bit is set.
- R6: Interrupt k is exception 16+k at level `irqPrio[k*P +: P]`. It targets Non-secure exactly when its assignment bit is 1, and every assignment bit is 0 (Secure) after reset. A write with `cfgSel`=1 and `cfgIdx`=16+k sets the bit to `cfgVal`. The write is ignored when `cfgNs`=1.
- R7: `vecAddr` equals four times `excNum`.
- R8: A configurable exception (R4, R6) is a candidate only while its enable bit is 1, and all enables are 0 after reset. A write with `cfgSel`=0 sets the enable of exception `cfgIdx` to `cfgVal`. A write with `cfgNs`=1 is ignored when that exception targets Secure.
- R9: A candidate qualifies only if its signed level is strictly less than `execPrio`. When `execPrio` is -4 or lower, nothing qualifies.
- R10: Among qualifying candidates, the lowest level wins. Equal levels go to the lowest exception number.
- R11: The outputs register the decision made from the inputs of the previous cycle. When nothing qualifies, and after reset, `valid`, `excNum`, `vecAddr` and `targetNs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysPend | input | 16 | Pending line per system exception number |
| sysPrio | input | 16*P | Configurable level per system exception number |
| sysBankNs | input | 16 | Bank that raised each banked system exception (1 = Non-secure) |
| irqPend | input | N | Pending line per peripheral interrupt |
| irqPrio | input | N*P | Configurable level per peripheral interrupt |
| routeNs | input | 1 | Global security routing bit |
| hfTargetNs | input | 1 | Pending HardFault targets Non-secure |
| execPrio | input | P+2 | Current execution priority, signed |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = enable bit, 1 = interrupt security bit |
| cfgIdx | input | NUMW | Exception number addressed by the write |
| cfgVal | input | 1 | Value written |
| cfgNs | input | 1 | Write comes from Non-secure software |
| valid | output | 1 | A candidate qualified |
| excNum | output | NUMW | Selected exception number |
| vecAddr | output | NUMW+2 | Vector address of the selection |
| targetNs | output | 1 | Selection targets Non-secure |

## Verification
The reset-wins and blocking properties compare against `execPrio` and `sysPend` one cycle back. They assume both are driven from ordinary registered logic that holds steady across the clock edge. They also assume the reset line is not pending while reset is applied. The bench changes all inputs only on the falling edge, keeps `sysPend` at zero during reset, and walks `execPrio` only through values from -4 up to 2^P.

// File: rtl/exc_prio_sel_pkg.sv
package exc_prio_sel_pkg;
  localparam int SYS_LINES = 16;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic nsSet;
    logic nsClr;
  } cfgStrobe_t;

  function automatic logic isConfigurable(input int num, input int total);
    if (num >= SYS_LINES) return num < total;
    return (num >= 4 && num <= 7) || num == 11 || num == 12 || num == 14 || num == 15;
  endfunction
endpackage

// File: rtl/exc_prio_sel_ctrl.sv
module exc_prio_sel_ctrl
  import exc_prio_sel_pkg::*;
#(
  parameter int N = 8,
  localparam int TOT = SYS_LINES + N,
  localparam int NUMW = $clog2(TOT)
) (
  input  logic            cfgWr,
  input  logic            cfgSel,
  input  logic [NUMW-1:0] cfgIdx,
  input  logic            cfgVal,
  input  logic            cfgNs,
  input  logic [TOT-1:0]  tgtNsVec,
  output cfgStrobe_t      strobe,
  output logic [NUMW-1:0] strobeIdx
);
  logic inRange;
  logic tgtBit;
  logic enAllowed;
  logic nsAllowed;

  always_comb begin
    inRange   = int'(cfgIdx) < TOT;
    tgtBit    = inRange ? tgtNsVec[cfgIdx] : 1'b0;
    enAllowed = cfgWr && !cfgSel && isConfigurable(int'(cfgIdx), TOT) && (!cfgNs || tgtBit);
    nsAllowed = cfgWr && cfgSel && !cfgNs && inRange && int'(cfgIdx) >= SYS_LINES;
    strobe.enSet = enAllowed && cfgVal;
    strobe.enClr = enAllowed && !cfgVal;
    strobe.nsSet = nsAllowed && cfgVal;
    strobe.nsClr = nsAllowed && !cfgVal;
    strobeIdx = cfgIdx;
  end
endmodule

// File: rtl/exc_prio_sel_dp.sv
module exc_prio_sel_dp
  import exc_prio_sel_pkg::*;
#(
  parameter int N = 8,
  parameter int P = 3,
  localparam int TOT = SYS_LINES + N,
  localparam int NUMW = $clog2(TOT),
  localparam int ADDRW = NUMW + 2,
  localparam int W = P + 2,
  localparam int IRQW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic [NUMW-1:0]     strobeIdx,
  input  logic [15:0]         sysPend,
  input  logic [16*P-1:0]     sysPrio,
  input  logic [15:0]         sysBankNs,
  input  logic [N-1:0]        irqPend,
  input  logic [N*P-1:0]      irqPrio,
  input  logic                routeNs,
  input  logic                hfTargetNs,
  input  logic signed [W-1:0] execPrio,
  output logic [TOT-1:0]      tgtNsVec,
  output logic                valid,
  output logic [NUMW-1:0]     excNum,
  output logic [ADDRW-1:0]    vecAddr,
  output logic                targetNs
);
  logic [TOT-1:0]      enReg;
  logic [N-1:0]        irqNsReg;
  logic [NUMW-1:0]     irqSel;
  logic                candReq  [TOT];
  logic signed [W-1:0] candPrio [TOT];
  logic                candTgt  [TOT];
  logic [15:0]         unusedSys;
  logic                unusedIdx;

  assign irqSel    = strobeIdx - NUMW'(SYS_LINES);
  assign unusedIdx = ^irqSel[NUMW-1:IRQW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      irqNsReg <= '0;
    end else begin
      if (strobe.enSet) enReg[strobeIdx] <= 1'b1;
      if (strobe.enClr) enReg[strobeIdx] <= 1'b0;
      if (strobe.nsSet) irqNsReg[irqSel[IRQW-1:0]] <= 1'b1;
      if (strobe.nsClr) irqNsReg[irqSel[IRQW-1:0]] <= 1'b0;
    end
  end

  for (genvar g = 0; g < SYS_LINES; g++) begin : gSys
    if (g == 1) begin : gReset
      assign candReq[g]   = sysPend[g];
      assign candPrio[g]  = W'(-4);
      assign candTgt[g]   = 1'b0;
      assign unusedSys[g] = ^{sysBankNs[g], sysPrio[g*P +: P], enReg[g]};
    end else if (g == 2) begin : gNmi
      assign candReq[g]   = sysPend[g];
      assign candPrio[g]  = W'(-2);
      assign candTgt[g]   = routeNs;
      assign unusedSys[g] = ^{sysBankNs[g], sysPrio[g*P +: P], enReg[g]};
    end else if (g == 3) begin : gHard
      assign candReq[g]   = sysPend[g];
      assign candPrio[g]  = (routeNs && !hfTargetNs) ? W'(-3) : W'(-1);
      assign candTgt[g]   = routeNs && hfTargetNs;
      assign unusedSys[g] = ^{sysBankNs[g], sysPrio[g*P +: P], enReg[g]};
    end else if (isConfigurable(g, TOT)) begin : gCfg
      assign candReq[g]  = sysPend[g] && enReg[g];
      assign candPrio[g] = $signed({2'b00, sysPrio[g*P +: P]});
      if (g == 5) begin : gBus
        assign candTgt[g]   = routeNs;
        assign unusedSys[g] = sysBankNs[g];
      end else if (g == 7) begin : gSecF
        assign candTgt[g]   = 1'b0;
        assign unusedSys[g] = sysBankNs[g];
      end else begin : gBanked
        assign candTgt[g]   = sysBankNs[g];
        assign unusedSys[g] = 1'b0;
      end
    end else begin : gReserved
      assign candReq[g]   = 1'b0;
      assign candPrio[g]  = '0;
      assign candTgt[g]   = 1'b0;
      assign unusedSys[g] = ^{sysPend[g], sysBankNs[g], sysPrio[g*P +: P], enReg[g]};
    end
  end

  for (genvar k = 0; k < N; k++) begin : gIrq
    assign candReq[SYS_LINES+k]  = irqPend[k] && enReg[SYS_LINES+k];
    assign candPrio[SYS_LINES+k] = $signed({2'b00, irqPrio[k*P +: P]});
    assign candTgt[SYS_LINES+k]  = irqNsReg[k];
  end

  for (genvar t = 0; t < TOT; t++) begin : gTgt
    assign tgtNsVec[t] = candTgt[t];
  end

  logic                bestHit;
  logic signed [W-1:0] bestPrio;
  logic [NUMW-1:0]     bestNum;
  logic                bestTgt;

  always_comb begin
    bestHit  = 1'b0;
    bestPrio = execPrio;
    bestNum  = '0;
    bestTgt  = 1'b0;
    for (int e = 0; e < TOT; e++) begin
      if (candReq[e] && candPrio[e] < bestPrio) begin
        bestHit  = 1'b1;
        bestPrio = candPrio[e];
        bestNum  = NUMW'(e);
        bestTgt  = candTgt[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid    <= 1'b0;
      excNum   <= '0;
      vecAddr  <= '0;
      targetNs <= 1'b0;
    end else begin
      valid    <= bestHit;
      excNum   <= bestNum;
      vecAddr  <= {bestNum, 2'b00};
      targetNs <= bestTgt;
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_prio_sel_pkg::*;
#(
  parameter int N = 8,
  parameter int P = 3,
  localparam int TOT = SYS_LINES + N,
  localparam int NUMW = $clog2(TOT),
  localparam int ADDRW = NUMW + 2,
  localparam int W = P + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [15:0]         sysPend,
  input  logic [16*P-1:0]     sysPrio,
  input  logic [15:0]         sysBankNs,
  input  logic [N-1:0]        irqPend,
  input  logic [N*P-1:0]      irqPrio,
  input  logic                routeNs,
  input  logic                hfTargetNs,
  input  logic signed [W-1:0] execPrio,
  input  logic                cfgWr,
  input  logic                cfgSel,
  input  logic [NUMW-1:0]     cfgIdx,
  input  logic                cfgVal,
  input  logic                cfgNs,
  output logic                valid,
  output logic [NUMW-1:0]     excNum,
  output logic [ADDRW-1:0]    vecAddr,
  output logic                targetNs
);
  cfgStrobe_t      strobe;
  logic [NUMW-1:0] strobeIdx;
  logic [TOT-1:0]  tgtNsVec;

  exc_prio_sel_ctrl #(.N(N)) ctrl_i (
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgVal(cfgVal), .cfgNs(cfgNs),
    .tgtNsVec(tgtNsVec), .strobe(strobe), .strobeIdx(strobeIdx)
  );

  exc_prio_sel_dp #(.N(N), .P(P)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .strobeIdx(strobeIdx),
    .sysPend(sysPend), .sysPrio(sysPrio), .sysBankNs(sysBankNs),
    .irqPend(irqPend), .irqPrio(irqPrio), .routeNs(routeNs), .hfTargetNs(hfTargetNs),
    .execPrio(execPrio), .tgtNsVec(tgtNsVec), .valid(valid), .excNum(excNum),
    .vecAddr(vecAddr), .targetNs(targetNs)
  );
endmodule

// File: rtl/exc_prio_sel_chk.sv
module exc_prio_sel_chk #(
  parameter int N = 8,
  parameter int P = 3,
  localparam int TOT = 16 + N,
  localparam int NUMW = $clog2(TOT),
  localparam int ADDRW = NUMW + 2,
  localparam int W = P + 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [15:0]         sysPend,
  input logic [16*P-1:0]     sysPrio,
  input logic [15:0]         sysBankNs,
  input logic [N-1:0]        irqPend,
  input logic [N*P-1:0]      irqPrio,
  input logic                routeNs,
  input logic                hfTargetNs,
  input logic signed [W-1:0] execPrio,
  input logic                cfgWr,
  input logic                cfgSel,
  input logic [NUMW-1:0]     cfgIdx,
  input logic                cfgVal,
  input logic                cfgNs,
  input logic                valid,
  input logic [NUMW-1:0]     excNum,
  input logic [ADDRW-1:0]    vecAddr,
  input logic                targetNs
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(sysPend[1]) && ($past(execPrio) > W'(-4)) |-> valid && excNum == NUMW'(1) && !targetNs);

  assert_nmi_route_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed && valid && excNum == NUMW'(2) |-> targetNs == $past(routeNs));

  assert_secfault_secure_R4: assert property (@(posedge clk) disable iff (!rstN)
    valid && excNum == NUMW'(7) |-> !targetNs);

  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> !(excNum inside {NUMW'(0), NUMW'(8), NUMW'(9), NUMW'(10), NUMW'(13)}));

  assert_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> vecAddr == {excNum, 2'b00});

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed && ($past(execPrio) <= W'(-4)) |-> !valid);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> excNum == '0 && vecAddr == '0 && !targetNs);
endmodule

bind exc_prio_sel exc_prio_sel_chk #(.N(N), .P(P)) chk_i (.*);

// File: tb/exc_prio_sel_tb_top.sv
module exc_prio_sel_tb_top;
  localparam int N = 8;
  localparam int P = 3;
  localparam int TOT = 16 + N;
  localparam int NUMW = $clog2(TOT);
  localparam int ADDRW = NUMW + 2;
  localparam int W = P + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rstN = 1'b0;
  logic [15:0]         sysPend = '0;
  logic [16*P-1:0]     sysPrio = '0;
  logic [15:0]         sysBankNs = '0;
  logic [N-1:0]        irqPend = '0;
  logic [N*P-1:0]      irqPrio = '0;
  logic                routeNs = 1'b0;
  logic                hfTargetNs = 1'b0;
  logic signed [W-1:0] execPrio = W'(8);
  logic                cfgWr = 1'b0, cfgSel = 1'b0, cfgVal = 1'b0, cfgNs = 1'b0;
  logic [NUMW-1:0]     cfgIdx = '0;
  logic                valid, targetNs;
  logic [NUMW-1:0]     excNum;
  logic [ADDRW-1:0]    vecAddr;

  exc_prio_sel #(.N(N), .P(P)) dut_i (.*);

  typedef struct {
    bit    v;
    int    num;
    bit    ns;
    string tag;
  } exp_t;

  exp_t  scoreQ[$];
  event  sampleEv;
  int    vectors = 0;
  int    miscompares = 0;
  bit    enM [TOT];
  bit    nsM [N];
  bit    done = 0;

  function automatic bit cfgNum(int n);
    if (n >= 16) return n < TOT;
    return (n >= 4 && n <= 7) || n == 11 || n == 12 || n == 14 || n == 15;
  endfunction

  function automatic bit tgtOf(int n);
    if (n >= 16) return nsM[n-16];
    case (n)
      2, 5: return routeNs;
      3: return routeNs && hfTargetNs;
      4, 6, 11, 12, 14, 15: return sysBankNs[n];
      default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t model(string tag);
    exp_t r;
    int best = int'(execPrio);
    r.v = 0; r.num = 0; r.ns = 0; r.tag = tag;
    for (int n = 1; n < TOT; n++) begin
      bit req; int p;
      req = 0; p = 0;
      if (n >= 16) begin
        req = irqPend[n-16] && enM[n];
        p = int'(irqPrio[(n-16)*P +: P]);
      end else if (n == 1) begin
        req = sysPend[1]; p = -4;
      end else if (n == 2) begin
        req = sysPend[2]; p = -2;
      end else if (n == 3) begin
        req = sysPend[3]; p = (routeNs && !hfTargetNs) ? -3 : -1;
      end else if (cfgNum(n)) begin
        req = sysPend[n] && enM[n];
        p = int'(sysPrio[n*P +: P]);
      end
      if (req && p < best) begin
        best = p; r.v = 1; r.num = n; r.ns = tgtOf(n);
      end
    end
    return r;
  endfunction

  task automatic cfgWrite(bit sel, int idx, bit val, bit ns);
    cfgWr = 1; cfgSel = sel; cfgIdx = NUMW'(idx); cfgVal = val; cfgNs = ns;
    if (!sel && cfgNum(idx) && (!ns || tgtOf(idx))) enM[idx] = val;
    if (sel && !ns && idx >= 16 && idx < TOT) nsM[idx-16] = val;
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic expectNow(string tag);
    scoreQ.push_back(model(tag));
    @(posedge clk);
    @(negedge clk);
    ->sampleEv;
  endtask

  task automatic setSysPrio(int n, int v);
    sysPrio[n*P +: P] = P'(v);
  endtask

  task automatic setIrqPrio(int k, int v);
    irqPrio[k*P +: P] = P'(v);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(sampleEv);
      e = scoreQ.pop_front();
      vectors++;
      if (valid !== e.v || int'(excNum) != e.num || int'(vecAddr) != e.num * 4 || targetNs !== e.ns) begin
        miscompares++;
        $display("FAIL %s: got valid=%0b num=%0d vec=0x%0h ns=%0b, expected valid=%0b num=%0d vec=0x%0h ns=%0b",
                 e.tag, valid, excNum, vecAddr, targetNs, e.v, e.num, e.num * 4, e.ns);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < TOT; i++) enM[i] = 0;
    for (int i = 0; i < N; i++) nsM[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (valid !== 0 || excNum !== 0 || vecAddr !== 0 || targetNs !== 0) begin
      miscompares++;
      $display("FAIL R11 reset: got valid=%0b num=%0d vec=%0d ns=%0b, expected all 0", valid, excNum, vecAddr, targetNs);
    end
    rstN = 1;
    @(negedge clk);
    expectNow("R11 nothing pending");

    for (int r = 0; r < 2; r++) begin
      routeNs = r[0];
      sysPend = '0; sysPend[1] = 1; sysPend[2] = 1; sysPend[3] = 1;
      expectNow("R1 reset over all");
      sysPend = '0; sysPend[2] = 1;
      expectNow("R2 NMI alone routed");
      sysPend = '0; sysPend[3] = 1; hfTargetNs = 0;
      expectNow("R3 HardFault secure alone");
      sysPend[2] = 1;
      expectNow("R3 HardFault secure vs NMI");
      hfTargetNs = 1;
      expectNow("R3 HardFault ns-request vs NMI");
      sysPend = '0; sysPend[3] = 1;
      expectNow("R3 HardFault ns-request alone");
      hfTargetNs = 0;
      sysPend = '0;
    end

    routeNs = 0;
    sysPend = '0; sysPend[0] = 1; sysPend[8] = 1; sysPend[9] = 1; sysPend[10] = 1; sysPend[13] = 1;
    expectNow("R5 reserved only");
    sysPend = '0;

    sysPend[5] = 1; setSysPrio(5, 1);
    expectNow("R8 BusFault disabled");
    cfgWrite(0, 5, 1, 0);
    expectNow("R4 BusFault route 0");
    routeNs = 1;
    expectNow("R4 BusFault route 1");
    cfgWrite(0, 7, 1, 1);
    sysPend = '0; sysPend[7] = 1; setSysPrio(7, 0);
    expectNow("R8 ns enable of SecureFault ignored");
    cfgWrite(0, 7, 1, 0);
    expectNow("R4 SecureFault secure");
    sysPend = '0; sysPend[11] = 1; sysBankNs[11] = 1; setSysPrio(11, 2);
    cfgWrite(0, 11, 1, 1);
    expectNow("R4 SVC ns bank");
    sysBankNs[11] = 0;
    expectNow("R4 SVC secure bank");
    sysPend = '0;

    for (int k = 0; k < N; k++) setIrqPrio(k, 5);
    setIrqPrio(3, 2); setIrqPrio(5, 2);
    cfgWrite(0, 19, 1, 0);
    cfgWrite(0, 21, 1, 0);
    irqPend = '0; irqPend[3] = 1; irqPend[5] = 1;
    expectNow("R10 tie picks 19");
    setIrqPrio(5, 1);
    expectNow("R10 lower level wins");
    execPrio = W'(1);
    expectNow("R9 equal level blocked");
    execPrio = W'(2);
    expectNow("R9 one above passes");
    irqPend = '0; irqPend[0] = 1;
    cfgWrite(0, 16, 1, 0);
    execPrio = W'(8);
    expectNow("R6 irq0 vector 0x40 secure");
    cfgWrite(0, 16, 0, 1);
    expectNow("R8 ns disable of secure irq ignored");
    cfgWrite(1, 16, 1, 1);
    expectNow("R6 ns write to assignment ignored");
    cfgWrite(1, 16, 1, 0);
    expectNow("R6 irq0 now Non-secure");
    cfgWrite(0, 16, 0, 1);
    expectNow("R8 ns disable of ns irq takes effect");
    irqPend = '0;

    routeNs = 1;
    sysPend = '0; sysPend[2] = 1; sysPend[3] = 1; hfTargetNs = 0;
    execPrio = W'(-2);
    expectNow("R9 exec -2 lets secure HardFault pass");
    hfTargetNs = 1;
    expectNow("R9 exec -2 blocks NMI and ns HardFault");
    sysPend[1] = 1;
    execPrio = W'(-4);
    expectNow("R9 exec -4 blocks reset");
    execPrio = W'(-3);
    expectNow("R1 reset at exec -3");
    sysPend = '0;
    execPrio = W'(8);
    expectNow("R11 idle again");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule